// File: doc/BRIEF.md
# Shared DMA-Request / Interrupt Pin Controller

Each of two channels owns one external input pin whose meaning depends on that channel's DMA setup. If the channel's DMA is enabled and paced by external synchronization, the pin is a level request for the DMA engine. The request passes through a two-flop synchronizer and is never latched. In every other setup the same pin is an extra maskable interrupt input. The synchronized pin feeds a rising-edge detector, and each detected edge sets a pending bit for that channel.

Channel 0 interrupts report vector type 0x0A and channel 1 interrupts report 0x0B. Each channel's interrupt uses that channel's mask bit. An acknowledge carrying a vector type clears the pending bit of the channel with that type. When both channels have an unmasked pending bit, channel 0 is presented first. The DMA engine and the system interrupt priority resolver sit outside this block.

Top module: `dpic_pin_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, dma_req_o and irq_req_o are 0 and irq_vec_o is 0x00 until a pin event is synchronized.
- R2: A channel is in DMA mode when dma_en_i and ext_sync_i are both 1 for that channel. In DMA mode, dma_req_o of that channel equals its pin as sampled two rising clock edges earlier.
- R3: The DMA request is not latched. Once the pin falls, dma_req_o falls two edges later, even though no transfer was serviced.
- R4: In DMA mode, pin activity never creates a pending interrupt.
- R5: When a channel is not in DMA mode, its dma_req_o is 0.
- R6: Outside DMA mode, a 0-to-1 pin transition makes irq_req_o 1 three edges later. irq_vec_o then reads 0x0A for channel 0 or 0x0B for channel 1.
- R7: An input held high produces one interrupt only. After it is acknowledged, no new request is made while the pin stays high.
- R8: A falling pin, or a pin that stays low, raises no interrupt.
- R9: With irq_mask_i of a channel at 1, that channel's pending interrupt is hidden from irq_req_o but kept. Clearing the mask presents it.
- R10: ack_i with ack_vec_i equal to a channel's vector type clears only that channel's pending bit. An acknowledge with any other type has no effect.
- R11: When both channels have an unmasked pending bit, irq_vec_o shows 0x0A. After that is acknowledged, it shows 0x0B.
- R12: When irq_req_o is 0, irq_vec_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 2 | Raw external pins, one per channel |
| dma_en_i | input | 2 | DMA channel enabled |
| ext_sync_i | input | 2 | DMA channel uses external synchronization |
| irq_mask_i | input | 2 | Interrupt mask per channel, 1 = masked |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_vec_i | input | 8 | Vector type being acknowledged |
| dma_req_o | output | 2 | Synchronized level DMA request per channel |
| irq_req_o | output | 1 | Interrupt request |
| irq_vec_o | output | 8 | Vector type of the presented interrupt |

## Verification
The bench targets the latency of the synchronizer path and of the edge path. A design with a missing or extra stage would assert requests a cycle early or late. It holds pins high across acknowledges, where a level-triggered design would raise the interrupt again. It toggles pins while the channel is in DMA mode, where a design that does not gate the edge detector would leave stray pending interrupts. It also checks masking, mismatched acknowledge types and simultaneous requests. A design that clears pending bits on mask, acknowledges the wrong channel, or inverts the priority would show the wrong vector or lose a request.

// File: rtl/dpic_pkg.sv
package dpic_pkg;
  localparam int unsigned VEC_W = 8;
  localparam logic [VEC_W-1:0] VEC_BASE = 8'h0A;
endpackage

// File: rtl/dpic_sync.sv
module dpic_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] ff_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[0], d_i};
  end
  assign q_o = ff_q[1];
endmodule

// File: rtl/dpic_chan.sv
module dpic_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic dma_en_i,
  input  logic ext_sync_i,
  input  logic mask_i,
  input  logic ack_hit_i,
  output logic dma_req_o,
  output logic pend_o,
  output logic irq_o
);
  logic pin_s, pin_d, dma_mode, rise;

  dpic_sync i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  assign dma_mode  = dma_en_i & ext_sync_i;
  assign dma_req_o = dma_mode & pin_s;
  assign rise      = pin_s & ~pin_d & ~dma_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_d  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      pin_d  <= pin_s;
      // a fresh edge wins over a same-cycle acknowledge
      pend_o <= rise | (pend_o & ~ack_hit_i);
    end
  end

  assign irq_o = pend_o & ~mask_i;
endmodule

// File: rtl/dpic_prio.sv
module dpic_prio #(
  parameter int unsigned N_CH  = 2,
  parameter int unsigned VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h0A
) (
  input  logic [N_CH-1:0]  req_i,
  output logic             any_o,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    any_o = 1'b0;
    vec_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        vec_o = VEC_BASE + VEC_W'(i);
      end
    end
  end
endmodule

// File: rtl/dpic_pin_ctrl.sv
module dpic_pin_ctrl
  import dpic_pkg::*;
#(
  parameter int unsigned N_CH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CH-1:0]  pin_i,
  input  logic [N_CH-1:0]  dma_en_i,
  input  logic [N_CH-1:0]  ext_sync_i,
  input  logic [N_CH-1:0]  irq_mask_i,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] ack_vec_i,
  output logic [N_CH-1:0]  dma_req_o,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  logic [N_CH-1:0] pend, irq;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic ack_hit;
    assign ack_hit = ack_i && (ack_vec_i == VEC_BASE + VEC_W'(g));
    dpic_chan i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[g]),
      .dma_en_i   (dma_en_i[g]),
      .ext_sync_i (ext_sync_i[g]),
      .mask_i     (irq_mask_i[g]),
      .ack_hit_i  (ack_hit),
      .dma_req_o  (dma_req_o[g]),
      .pend_o     (pend[g]),
      .irq_o      (irq[g])
    );
  end

  dpic_prio #(.N_CH(N_CH), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) i_prio (
    .req_i (irq),
    .any_o (irq_req_o),
    .vec_o (irq_vec_o)
  );
endmodule

// File: rtl/dpic_pin_ctrl_chk.sv
module dpic_pin_ctrl_chk
  import dpic_pkg::*;
#(
  parameter int unsigned N_CH = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_CH-1:0]  pin_i,
  input logic [N_CH-1:0]  dma_en_i,
  input logic [N_CH-1:0]  ext_sync_i,
  input logic [N_CH-1:0]  irq_mask_i,
  input logic             ack_i,
  input logic [VEC_W-1:0] ack_vec_i,
  input logic [N_CH-1:0]  dma_req_o,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic [N_CH-1:0]  pend
);
  p_idle_vec_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_req_o |-> irq_vec_o == '0);

  p_vec_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_vec_o >= VEC_BASE && irq_vec_o < VEC_BASE + VEC_W'(N_CH)));

  p_ch0_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[0] && !irq_mask_i[0]) |-> irq_vec_o == VEC_BASE);

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    p_dma_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dma_en_i[g] && ext_sync_i[g]) |-> !dma_req_o[g]);

    p_dma_sync_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dma_req_o[g] |-> $past(pin_i[g], 2));

    p_mask_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend[g] && !(ack_i && ack_vec_i == VEC_BASE + VEC_W'(g))) |=> pend[g]);
  end
endmodule

bind dpic_pin_ctrl dpic_pin_ctrl_chk #(.N_CH(N_CH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pin_i      (pin_i),
  .dma_en_i   (dma_en_i),
  .ext_sync_i (ext_sync_i),
  .irq_mask_i (irq_mask_i),
  .ack_i      (ack_i),
  .ack_vec_i  (ack_vec_i),
  .dma_req_o  (dma_req_o),
  .irq_req_o  (irq_req_o),
  .irq_vec_o  (irq_vec_o),
  .pend       (pend)
);

// File: tb/test_dpic_pin_ctrl.sv
`timescale 1ns/1ps
module test_dpic_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin = '0, en = '0, es = '0, msk = '0;
  logic       ack = 1'b0;
  logic [7:0] ack_vec = '0;
  logic [1:0] dma_req;
  logic       irq_req;
  logic [7:0] irq_vec;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpic_pin_ctrl i_dpic_pin_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .dma_en_i(en), .ext_sync_i(es),
    .irq_mask_i(msk), .ack_i(ack), .ack_vec_i(ack_vec),
    .dma_req_o(dma_req), .irq_req_o(irq_req), .irq_vec_o(irq_vec)
  );

  // reference model built from the requirements
  logic [1:0] m_s0, m_s1, m_prev, m_pend;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 <= '0; m_s1 <= '0; m_prev <= '0; m_pend <= '0;
    end else begin
      m_s0 <= pin; m_s1 <= m_s0; m_prev <= m_s1;
      for (int c = 0; c < 2; c++) begin
        logic mode, hit;
        mode = en[c] & es[c];
        hit  = ack && (ack_vec == 8'h0A + 8'(c));
        m_pend[c] <= (m_s1[c] & ~m_prev[c] & ~mode) | (m_pend[c] & ~hit);
      end
    end
  end

  function automatic logic [1:0] exp_dma();
    return en & es & m_s1;
  endfunction
  function automatic logic [7:0] exp_vec();
    logic [1:0] v = m_pend & ~msk;
    if (v[0]) return 8'h0A;
    if (v[1]) return 8'h0B;
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_ack(logic [7:0] v);
    ack = 1'b1; ack_vec = v;
    step(1);
    ack = 1'b0; ack_vec = '0;
  endtask

  initial begin
    // R1 reset, pins active
    pin = 2'b11; en = 2'b11; es = 2'b11;
    step(3);
    chk("R1 dma_req in reset", dma_req, 0);
    chk("R1 irq_req in reset", irq_req, 0);
    chk("R1 irq_vec in reset", irq_vec, 0);
    pin = '0; en = '0; es = '0;
    step(1);
    rst_n = 1'b1;
    step(1);
    chk("R1 dma_req after reset", dma_req, 0);
    chk("R12 idle vec", irq_vec, 0);

    // R2 DMA mode level path
    en = 2'b01; es = 2'b01; pin = 2'b01;
    step(1);
    chk("R2 not yet synced", dma_req, 2'b00);
    step(1);
    chk("R2 dma_req ch0 after 2 edges", dma_req, 2'b01);
    step(2);
    chk("R4 no irq in dma mode", irq_req, 0);
    // R3 unlatched
    pin = 2'b00;
    step(2);
    chk("R3 dma_req drops with pin", dma_req, 2'b00);
    step(2);
    chk("R4 no irq after dma pulse", irq_req, 0);

    // R5/R6 ext sync off: interrupt mode
    es = 2'b00; pin = 2'b01;
    step(2);
    chk("R5 dma_req low without ext sync", dma_req, 2'b00);
    chk("R6 not yet pending", irq_req, 0);
    step(1);
    chk("R6 irq ch0", irq_req, 1);
    chk("R6 vec ch0", irq_vec, 8'h0A);
    step(4);
    do_ack(8'h0A);
    chk("R7 cleared by ack", irq_req, 0);
    step(6);
    chk("R7 held level no retrigger", irq_req, 0);
    pin = 2'b00;
    step(5);
    chk("R8 falling edge no irq", irq_req, 0);

    // ch1 interrupt, wrong ack
    en = 2'b00; pin = 2'b10;
    step(3);
    chk("R6 vec ch1", irq_vec, 8'h0B);
    do_ack(8'h0A);
    chk("R10 wrong-type ack ignored", irq_vec, 8'h0B);
    do_ack(8'h55);
    chk("R10 foreign ack ignored", irq_req, 1);
    do_ack(8'h0B);
    chk("R10 matching ack clears", irq_req, 0);
    pin = 2'b00;
    step(2);

    // R9 mask
    msk = 2'b01; pin = 2'b01;
    step(4);
    chk("R9 masked hidden", irq_req, 0);
    msk = 2'b00;
    #1;
    chk("R9 unmask shows kept pending", irq_vec, 8'h0A);
    do_ack(8'h0A);
    pin = 2'b00;
    step(2);

    // R11 both pending
    pin = 2'b11;
    step(3);
    chk("R11 ch0 first", irq_vec, 8'h0A);
    do_ack(8'h0A);
    chk("R11 ch1 next", irq_vec, 8'h0B);
    do_ack(8'h0B);
    chk("R11 both cleared", irq_req, 0);

    // constrained random, checked against model
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < 3000; k++) begin
      pin = 2'($urandom);
      if ($urandom % 16 == 0) begin en = 2'($urandom); es = 2'($urandom); end
      if ($urandom % 8 == 0) msk = 2'($urandom);
      ack = ($urandom % 4 == 0);
      case ($urandom % 3)
        0: ack_vec = 8'h0A;
        1: ack_vec = 8'h0B;
        default: ack_vec = 8'h55;
      endcase
      #1;
      chk("R2 R5 random dma_req", dma_req, exp_dma());
      chk("R6 R11 random vec", irq_vec, exp_vec());
      chk("R9 random irq_req", irq_req, exp_vec() != 0);
      step(1);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule